// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block turns a fast input clock into a slower card clock. A two-bit select picks one of four ratios: the input frequency itself, or one half, one quarter or one eighth of it. For every ratio of two or more, the output is a register in the input clock domain. It stays high for half the ratio and low for the other half. At divide by one, the output follows the input clock directly.

The select may change while the clock runs. The select bits first pass through a synchronizer. A new ratio is applied only at the instant one output period ends, which is the rising input edge that closes a low phase. Every phase next to a changeover therefore has the full width of its own ratio, and no runt pulse can appear. If both select bits change at once, the block moves to the target in two single-bit hops. It spends exactly one full output period at the intermediate ratio.

After reset the output is low and divide by eight is active. The first period after reset is always a divide-by-eight period. The synchronized select is used from the next period boundary on.

Top module: `cardclk_div`

## Requirements
- R1: The select code sets the ratio N of output period to input period as follows: 00 gives N=8, 01 gives N=4, 11 gives N=2 and 10 gives N=1.
- R2: For N of 2 or more, each output period is high for N/2 input periods and then low for N/2 input periods. For N=1, the output equals the input clock.
- R3: The ratio changes only at a rising input edge that ends a low phase. The first phase at the new ratio is high and has the full width of the new ratio. Every phase before it has the full width of the old ratio.
- R4: Once the synchronized select differs from the active code, a new code is applied at the next period boundary, which comes at most 8 input periods later. Measured from the first rising edge that captures a pin change, the first period at the new ratio starts no later than SYNC_STAGES+7 rising edges after that edge.
- R5: Each select bit passes through SYNC_STAGES flip-flops (default 2) before use. A pin change therefore cannot start a new period earlier than SYNC_STAGES rising edges after the first edge that captures it.
- R6: When the synchronized select differs from the active code in both bits, bit 0 flips first. One full output period runs at that intermediate code, and the target code is applied at the following boundary.
- R7: Reset is asynchronous and active low. While reset is held, the output is low and code 00 is active. The first output period after release is a divide-by-eight period that starts at the first rising edge, whatever the select is.
- R8: The active code changes by exactly one bit at each update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 2 | Ratio select code, asynchronous to clk_in |
| clk_out | output | 1 | Divided card clock |

## Verification
The bench samples the output once in every half input period: 1.25 ns after each rising edge and 1.25 ns after each falling edge. It then measures phase widths as runs of equal samples. A select change is driven 0.5 ns after a falling edge. That sample's index, m, fixes the timing. The capturing edge is sample m+1, the synchronizer delay puts the earliest new period at sample m+5, and a full divide-by-eight wait puts the latest at sample m+19. The bench checks that the first new-ratio phase starts inside that window. Steady-state widths are measured only after a 30-cycle settling gap. After a reset release, the divide-by-eight period is expected at samples m+1 to m+16, and the selected ratio only after that.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int SEL_W   = 2;
    localparam int MAX_DIV = 8;
    localparam int CNT_W   = $clog2(MAX_DIV);

    // Gray-ordered select codes: neighbours in ratio differ in one bit
    typedef enum logic [SEL_W-1:0] {
        SEL_DIV8 = 2'b00,
        SEL_DIV4 = 2'b01,
        SEL_DIV2 = 2'b11,
        SEL_DIV1 = 2'b10
    } sel_code_e;

    typedef struct packed {
        sel_code_e        code;
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             pass;
    } div_state_t;

    function automatic logic [CNT_W:0] ratio_of(sel_code_e c);
        case (c)
            SEL_DIV8: return (CNT_W+1)'(MAX_DIV);
            SEL_DIV4: return (CNT_W+1)'(MAX_DIV >> 1);
            SEL_DIV2: return (CNT_W+1)'(MAX_DIV >> 2);
            SEL_DIV1: return (CNT_W+1)'(1);
            default:  return (CNT_W+1)'(MAX_DIV);
        endcase
    endfunction

    // Move at most one bit toward the target; low bit first on a double change
    function automatic sel_code_e step_toward(sel_code_e cur, sel_code_e tgt);
        logic [SEL_W-1:0] diff;
        diff = cur ^ tgt;
        if (&diff) return sel_code_e'(cur ^ SEL_W'(1));
        return tgt;
    endfunction

endpackage

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
    import cdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  sel_code_e sel_sync,
    output sel_code_e code,
    output logic      lvl,
    output logic      pass,
    output logic      wrap
);

    localparam logic [CNT_W:0]   R_ONE = (CNT_W+1)'(1);
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam div_state_t RST_ST = '{
        code: SEL_DIV8,
        cnt:  CNT_W'(MAX_DIV - 1),
        lvl:  1'b0,
        pass: 1'b0
    };

    div_state_t       st_d, st_q;
    logic [CNT_W:0]   ratio_cur, ratio_nxt, half_cur;
    sel_code_e        code_nxt;
    logic             wrap_c;

    always_comb begin
        ratio_cur = ratio_of(st_q.code);
        half_cur  = ratio_cur >> 1;
        wrap_c    = ({1'b0, st_q.cnt} == (ratio_cur - R_ONE));
        code_nxt  = step_toward(st_q.code, sel_sync);
        ratio_nxt = ratio_of(code_nxt);
        st_d      = st_q;
        if (wrap_c) begin
            // period boundary: end of a low phase, safe to change ratio
            st_d.code = code_nxt;
            st_d.cnt  = '0;
            st_d.pass = (ratio_nxt == R_ONE);
            st_d.lvl  = (ratio_nxt != R_ONE);
        end else begin
            st_d.cnt  = st_q.cnt + C_ONE;
            st_d.lvl  = (({1'b0, st_q.cnt} + R_ONE) < half_cur);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign code = st_q.code;
    assign lvl  = st_q.lvl;
    assign pass = st_q.pass;
    assign wrap = wrap_c;

endmodule

// File: rtl/cdiv_outmux.sv
module cdiv_outmux (
    input  logic clk,
    input  logic pass,
    input  logic lvl,
    output logic clk_out
);

    // pass and lvl only change at rising clk edges, where both sides agree
    assign clk_out = pass ? clk : lvl;

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div
    import cdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             clk_out
);

    logic [SEL_W-1:0] sel_sync_raw;
    sel_code_e        sel_sync;
    sel_code_e        act_code;
    logic             lvl_q;
    logic             pass_q;
    logic             at_wrap;

    cdiv_sync #(
        .WIDTH   (SEL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SEL_W'(SEL_DIV8))
    ) u_sync (
        .clk   (clk_in),
        .rst_n (rst_n),
        .din   (div_sel),
        .dout  (sel_sync_raw)
    );

    assign sel_sync = sel_code_e'(sel_sync_raw);

    cdiv_core u_core (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .sel_sync (sel_sync),
        .code     (act_code),
        .lvl      (lvl_q),
        .pass     (pass_q),
        .wrap     (at_wrap)
    );

    cdiv_outmux u_mux (
        .clk     (clk_in),
        .pass    (pass_q),
        .lvl     (lvl_q),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/cardclk_div_chk.sv
module cardclk_div_chk
    import cdiv_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input sel_code_e code,
    input sel_code_e sel_sync,
    input logic      lvl,
    input logic      pass,
    input logic      wrap
);

    localparam logic [CNT_W:0] K1   = (CNT_W+1)'(1);
    localparam logic [CNT_W:0] LMAX = (CNT_W+1)'(MAX_DIV - 1);

    logic [CNT_W:0] hi_run_q;
    logic [CNT_W:0] lag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lag_q    <= '0;
        end else begin
            hi_run_q <= lvl ? hi_run_q + K1 : '0;
            lag_q    <= (wrap || code == sel_sync) ? '0 : lag_q + K1;
        end
    end

    // R7: held reset gives low output and code 00
    p_reset_state_r7: assert property (@(posedge clk)
        !rst_n |-> (code == SEL_DIV8 && !lvl && !pass));

    // R3: code moves only right after a period boundary
    p_switch_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> $past(wrap));

    // R8: one bit per update
    p_single_hop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> ($countones(code ^ $past(code)) == 1));

    // R2: high phase lasts half the ratio
    p_high_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl) |-> (hi_run_q == (ratio_of(code) >> 1)));

    // R4: a pending select is taken at the boundary
    p_pending_applied_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && code != sel_sync) |=> (code != $past(code)));

    // R4: boundary comes within the longest period
    p_lag_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lag_q <= LMAX);

    // R1: pass-through only at divide by one
    p_pass_div1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (code == SEL_DIV1 && !lvl));

endmodule

bind cardclk_div cardclk_div_chk u_chk (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .code     (act_code),
    .sel_sync (sel_sync),
    .lvl      (lvl_q),
    .pass     (pass_q),
    .wrap     (at_wrap)
);

// File: tb/cardclk_div_test.sv
`timescale 1ns/1ps
module cardclk_div_test;

    localparam int HMAX = 8192;
    localparam int SYNC = 2;
    localparam int NV   = 7;
    localparam int RMAX = 512;
    // select code, expected phase width in half input periods (= ratio)
    localparam int VEC [NV][2] = '{'{0, 8}, '{1, 4}, '{3, 2}, '{2, 1},
                                    '{3, 2}, '{1, 4}, '{0, 8}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       clk_out;

    bit hist [HMAX];
    int hcnt = 0;
    int rl [RMAX];
    bit rv [RMAX];
    int rp [RMAX];
    int nr;
    int nchk = 0;
    int nerr = 0;

    cardclk_div uut (.clk_in(clk), .rst_n(rst_n), .div_sel(sel), .clk_out(clk_out));

    always #2.5 clk = ~clk;

    // one output sample per half input period
    initial begin
        forever begin
            @(posedge clk); #1.25;
            if (hcnt < HMAX) hist[hcnt] = clk_out;
            hcnt++;
            @(negedge clk); #1.25;
            if (hcnt < HMAX) hist[hcnt] = clk_out;
            hcnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_sel(input logic [1:0] v, output int mark);
        @(negedge clk); #0.5;
        sel  = v;
        mark = hcnt;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic int ones(input int a, input int b);
        int c = 0;
        for (int i = a; i < b; i++) c += hist[i];
        return c;
    endfunction

    // full runs strictly inside [s, e)
    task automatic get_runs(input int s, input int e);
        int cs;
        cs = s;
        nr = 0;
        for (int i = s + 1; i <= e; i++) begin
            if (i == e || hist[i] != hist[cs]) begin
                if (cs != s && i != e && nr < RMAX) begin
                    rl[nr] = i - cs; rv[nr] = hist[cs]; rp[nr] = cs; nr++;
                end
                cs = i;
            end
        end
    endtask

    function automatic int first_not(input int len);
        for (int j = 0; j < nr; j++) if (rl[j] != len) return j;
        return -1;
    endfunction

    int m, s, e, prev, n, j, bad, badlen;

    initial begin
        // R7: low output while reset held
        wait_cyc(4);
        chk(ones(0, hcnt) == 0, "R7 output low in reset", ones(0, hcnt), 0);
        @(negedge clk); #0.5;
        rst_n = 1'b1;
        m = hcnt;
        wait_cyc(20);
        chk(ones(m + 1, m + 9) == 8, "R7 first period high half", ones(m + 1, m + 9), 8);
        chk(ones(m + 9, m + 17) == 0, "R7 first period low half", ones(m + 9, m + 17), 0);

        prev = 8;
        for (int i = 0; i < NV; i++) begin
            n = VEC[i][1];
            set_sel(VEC[i][0][1:0], m);
            wait_cyc(30);
            s = hcnt;
            wait_cyc(40);
            e = hcnt;
            // R1 / R2: steady widths
            get_runs(s, e);
            bad = 0; badlen = n;
            for (int k = 0; k < nr; k++) if (rl[k] != n) begin
                if (bad == 0) badlen = rl[k];
                bad++;
            end
            chk(bad == 0, "R2 steady phase width", badlen, n);
            chk(nr >= 8 && rv[0] != rv[1], "R1 alternating periods", nr, 8);
            if (prev != n) begin
                get_runs(m, s);
                j = first_not(prev);
                chk(j >= 0 && rl[j] == n && rv[j], "R3 first new phase full and high",
                    (j >= 0) ? rl[j] : -1, n);
                chk(j <= 0 || !rv[j-1], "R3 change follows a low phase", (j > 0) ? rv[j-1] : 0, 0);
                chk(j >= 0 && rp[j] <= m + 1 + 2 * (SYNC + 7), "R4 changeover bound",
                    (j >= 0) ? rp[j] - m : -1, 1 + 2 * (SYNC + 7));
                chk(j >= 0 && rp[j] >= m + 1 + 2 * SYNC, "R5 synchronizer delay",
                    (j >= 0) ? rp[j] - m : -1, 1 + 2 * SYNC);
                bad = 0;
                if (j >= 0) for (int k = j; k < nr; k++) if (rl[k] != n) bad++;
                chk(bad == 0, "R3 no runt after change", bad, 0);
            end
            prev = n;
        end

        // R6: double change 00 -> 11 passes through 01 for one period
        set_sel(2'b11, m);
        wait_cyc(40);
        get_runs(m, hcnt);
        j = first_not(8);
        chk(j >= 0 && rl[j] == 4 && rv[j], "R6 intermediate high (div4)", (j >= 0) ? rl[j] : -1, 4);
        chk(j >= 0 && rl[j+1] == 4 && !rv[j+1], "R6 intermediate low (div4)", (j >= 0) ? rl[j+1] : -1, 4);
        chk(j >= 0 && rl[j+2] == 2 && rv[j+2], "R6 target reached (div2)", (j >= 0) ? rl[j+2] : -1, 2);

        // R6: double change 11 -> 00 passes through 10 for one period
        set_sel(2'b00, m);
        wait_cyc(40);
        get_runs(m, hcnt);
        j = first_not(2);
        chk(j >= 0 && rl[j] == 1 && rv[j], "R6 intermediate high (div1)", (j >= 0) ? rl[j] : -1, 1);
        chk(j >= 0 && rl[j+1] == 1 && !rv[j+1], "R6 intermediate low (div1)", (j >= 0) ? rl[j+1] : -1, 1);
        chk(j >= 0 && rl[j+2] == 8 && rv[j+2], "R6 target reached (div8)", (j >= 0) ? rl[j+2] : -1, 8);

        // R7: reset mid-run at divide by one, select held at 10
        set_sel(2'b10, m);
        wait_cyc(30);
        @(negedge clk); #0.5;
        rst_n = 1'b0;
        m = hcnt;
        wait_cyc(4);
        chk(ones(m, m + 8) == 0, "R7 output low during mid-run reset", ones(m, m + 8), 0);
        @(negedge clk); #0.5;
        rst_n = 1'b1;
        m = hcnt;
        wait_cyc(20);
        chk(ones(m + 1, m + 9) == 8 && ones(m + 9, m + 17) == 0,
            "R7 div8 period first after reset", ones(m + 1, m + 17), 8);
        chk(hist[m + 17] && !hist[m + 18] && hist[m + 19], "R1 div1 after first period",
            int'(hist[m + 18]), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #1000000;
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule